// File: doc/BRIEF.md
# Dual-Channel Regulator Start-Up Sequencer

This block is the digital controller that powers up two regulator channels. Each channel has its own enable input. The analog steps that both channels share are a trim capture, a bandgap, a reference voltage, a bias current generator and a fast charge of the reference filter node. The block starts each of these steps with a one-cycle strobe and waits for a common done handshake before it moves to the next step. Once the shared steps have finished, it raises a ramp-go level for each channel. The analog ramp reports back through a per-channel target-reached input.

Channel 1 has priority. Channel 2 does not begin its ramp while channel 1 is enabled and has not yet reached its target. A channel 2 ramp that is already running does not block channel 1. The input-supply comparator, which has hysteresis, gates the whole sequence. When it drops, both channels go off at once, and when it returns the shared steps run again from the first one. A programmable per-step cycle limit catches a missing done handshake. When that limit is reached, the block parks in a fault state that clears only when both enables are low.

Top module: `rail_startup_seq`

## Requirements
- R1: Out of reset, and whenever both synchronised enables are low, `step_stb_o`, `ramp_go_o` and `fault_o` are all zero. In this state `step_done_i` and `ramp_done_i` have no effect.
- R2: No step strobe is issued while `uv_ok_i` is low, even with an enable high. The first strobe follows only after `uv_ok_i` is high.
- R3: The step strobes are one-cycle pulses on `step_stb_o` and at most one bit is high at a time. The fixed order is bit 0 trim capture, bit 1 bandgap, bit 2 reference voltage, bit 3 current generator, bit 4 filter fast charge. Each strobe after the first is issued in the cycle after `step_done_i` is seen high for the preceding step.
- R4: No `ramp_go_o` bit rises before the done for the fast-charge step (bit 4) has been accepted. Channel 1 rises exactly one cycle after the shared steps complete.
- R5: With both channels enabled together, `ramp_go_o[0]` rises first. `ramp_go_o[1]` rises two cycles after `ramp_done_i[0]` is driven high.
- R6: If channel 2 is enabled while channel 1 is ramping, `ramp_go_o[1]` stays low until channel 1 reports target, then rises two cycles after `ramp_done_i[0]`.
- R7: If channel 2 is enabled first and channel 1 is enabled during any of the shared steps, channel 1 ramps first and channel 2 waits for `ramp_done_i[0]`.
- R8: If channel 1 is enabled while `ramp_go_o[1]` is already high, `ramp_go_o[0]` rises three cycles after the enable input changes, with no wait on channel 2, and `ramp_go_o[1]` stays high.
- R9: `uv_ok_i` low clears both `ramp_go_o` bits in the next cycle. When it returns high, the shared steps restart from trim capture.
- R10: If `step_done_i` does not arrive within `step_tmo_i` cycles of a step's strobe (`step_tmo_i` ≥ 1), `fault_o` rises exactly `step_tmo_i` cycles after that strobe, with all strobes and ramps low. The fault holds, with no restart, until both enables are low, and it clears three cycles after that.
- R11: Enables pass through a two-stage synchroniser. Dropping one channel's enable while the other stays high clears only that channel's `ramp_go_o` bit, three cycles later, and issues no step strobe.
- R12: While the shared steps are complete, enabling a channel raises its `ramp_go_o` bit three cycles later with no step strobe, subject to R5–R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en_i | input | CHANNELS | Asynchronous channel enables, bit 0 = channel 1 (priority) |
| uv_ok_i | input | 1 | Input-supply comparator output with hysteresis, 1 = supply good |
| step_done_i | input | 1 | Done handshake for the shared step in progress |
| step_tmo_i | input | TMO_W | Cycle limit per shared step |
| ramp_done_i | input | CHANNELS | Per-channel target-reached handshake |
| step_stb_o | output | 5 | One-cycle start strobes for the shared steps |
| ramp_go_o | output | CHANNELS | Per-channel ramp/run enable level |
| fault_o | output | 1 | Step timeout fault |

## Verification
The bench builds the block with two channels and a 4-bit step limit. This keeps every limit from 1 to 4 cycles cheap to run, so each value is combined with a stall at each of the five shared steps. Channel 2 is held at every shared step while channel 1 joins late, which covers every window R7 describes. The channel 2 enable offset is also swept across channel 1's ramp. With the two-stage synchroniser, every enable response falls on a fixed cycle, so the bench checks ramp starts, drops and fault timing at exact offsets rather than within windows.

// File: rtl/rss_pkg.sv
// Shared types for the dual-channel start-up sequencer.
// Assumes the shared step states are contiguous, starting at RS_TRIM.
package rss_pkg;

    typedef enum logic [3:0] {
        RS_OFF,
        RS_UVWAIT,
        RS_TRIM,
        RS_BGAP,
        RS_VREF,
        RS_IGEN,
        RS_FCHG,
        RS_UP,
        RS_FAULT
    } ref_state_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_RAMP,
        CH_ON
    } chan_state_e;

    localparam int unsigned STEP_COUNT = 5;

    function automatic logic is_step(input ref_state_e s);
        return (s >= RS_TRIM) && (s <= RS_FCHG);
    endfunction

endpackage

// File: rtl/rss_sync.sv
// Multi-stage synchroniser for asynchronous level inputs.
// Assumes STAGES >= 2 and inputs that are quasi-static levels.
module rss_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rss_ref_fsm.sv
// Shared-step sequencer: supply gating, ordered step strobes with done
// handshake, per-step cycle limit and sticky fault.
// Assumes step_done is only meaningful while a step state is active.
module rss_ref_fsm
    import rss_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_any,
    input  logic                  uv_ok,
    input  logic                  step_done,
    input  logic [TMO_W-1:0]      step_tmo,
    output logic [STEP_COUNT-1:0] step_stb,
    output logic                  refs_up,
    output logic                  fault
);
    ref_state_e            st, nxt;
    logic [TMO_W-1:0]      tmo_cnt;
    logic [TMO_W:0]        cnt_plus;
    logic                  tmo_hit;
    logic [STEP_COUNT-1:0] stb_nxt;

    // Limit reached once this cycle would be the last allowed one.
    assign cnt_plus = {1'b0, tmo_cnt} + (TMO_W + 1)'(1);
    assign tmo_hit  = cnt_plus >= {1'b0, step_tmo};

    // Next-state decision for the shared sequence.
    always_comb begin
        nxt = st;
        if (st == RS_FAULT) begin
            if (!en_any) nxt = RS_OFF;
        end else if (!en_any) begin
            nxt = RS_OFF;
        end else if (st != RS_OFF && !uv_ok) begin
            nxt = RS_UVWAIT;
        end else begin
            case (st)
                RS_OFF:    nxt = RS_UVWAIT;
                RS_UVWAIT: nxt = RS_TRIM;
                RS_TRIM:   nxt = step_done ? RS_BGAP : (tmo_hit ? RS_FAULT : RS_TRIM);
                RS_BGAP:   nxt = step_done ? RS_VREF : (tmo_hit ? RS_FAULT : RS_BGAP);
                RS_VREF:   nxt = step_done ? RS_IGEN : (tmo_hit ? RS_FAULT : RS_VREF);
                RS_IGEN:   nxt = step_done ? RS_FCHG : (tmo_hit ? RS_FAULT : RS_IGEN);
                RS_FCHG:   nxt = step_done ? RS_UP   : (tmo_hit ? RS_FAULT : RS_FCHG);
                RS_UP:     nxt = RS_UP;
                default:   nxt = RS_OFF;
            endcase
        end
    end

    // One strobe bit per step, raised on entry into that step.
    for (genvar k = 0; k < STEP_COUNT; k++) begin : g_stb
        localparam logic [3:0] K_CODE = 4'(int'(RS_TRIM) + k);
        assign stb_nxt[k] = (nxt != st) && (4'(nxt) == K_CODE);
    end

    // State, strobe and step-timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RS_OFF;
            step_stb <= '0;
            tmo_cnt  <= '0;
        end else begin
            st       <= nxt;
            step_stb <= stb_nxt;
            if (nxt != st)       tmo_cnt <= '0;
            else if (is_step(st)) tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    assign refs_up = (st == RS_UP);
    assign fault   = (st == RS_FAULT);
endmodule

// File: rtl/rss_chan_arb.sv
// Per-channel ramp control with fixed priority: a channel may leave idle
// only when no lower-index channel is enabled and still short of target.
// A channel already ramping is never held back by a higher-index one.
// Assumes refs_up is a level that falls whenever the shared steps drop.
module rss_chan_arb
    import rss_pkg::*;
#(
    parameter int unsigned CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refs_up,
    input  logic [CHANNELS-1:0] en_s,
    input  logic [CHANNELS-1:0] ramp_done,
    output logic [CHANNELS-1:0] ramp_go,
    output logic [CHANNELS-1:0] chan_on
);
    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        chan_state_e cs, cn;
        logic        hold;

        if (i == 0) begin : g_top
            assign hold = 1'b0;
        end else begin : g_low
            assign hold = |(en_s[i-1:0] & ~chan_on[i-1:0]);
        end

        // Channel state transitions.
        always_comb begin
            cn = cs;
            if (!refs_up || !en_s[i]) begin
                cn = CH_IDLE;
            end else begin
                case (cs)
                    CH_IDLE: if (!hold)       cn = CH_RAMP;
                    CH_RAMP: if (ramp_done[i]) cn = CH_ON;
                    CH_ON:   cn = CH_ON;
                    default: cn = CH_IDLE;
                endcase
            end
        end

        // Channel state register.
        always_ff @(posedge clk) begin
            if (!rst_n) cs <= CH_IDLE;
            else        cs <= cn;
        end

        assign chan_on[i] = (cs == CH_ON);
        assign ramp_go[i] = refs_up && (cs != CH_IDLE);
    end
endmodule

// File: rtl/rail_startup_seq.sv
// Top of the dual-channel start-up sequencer: enable synchroniser,
// shared-step sequencer and channel arbiter.
// Assumes CHANNELS >= 2 and step_tmo_i >= 1.
module rail_startup_seq
    import rss_pkg::*;
#(
    parameter int unsigned CHANNELS    = 2,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHANNELS-1:0]   chan_en_i,
    input  logic                  uv_ok_i,
    input  logic                  step_done_i,
    input  logic [TMO_W-1:0]      step_tmo_i,
    input  logic [CHANNELS-1:0]   ramp_done_i,
    output logic [STEP_COUNT-1:0] step_stb_o,
    output logic [CHANNELS-1:0]   ramp_go_o,
    output logic                  fault_o
);
    logic [CHANNELS-1:0] en_sync;
    logic [CHANNELS-1:0] chan_on;
    logic                refs_up;

    rss_sync #(.WIDTH(CHANNELS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chan_en_i),
        .q     (en_sync)
    );

    rss_ref_fsm #(.TMO_W(TMO_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_any    (|en_sync),
        .uv_ok     (uv_ok_i),
        .step_done (step_done_i),
        .step_tmo  (step_tmo_i),
        .step_stb  (step_stb_o),
        .refs_up   (refs_up),
        .fault     (fault_o)
    );

    rss_chan_arb #(.CHANNELS(CHANNELS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .refs_up   (refs_up),
        .en_s      (en_sync),
        .ramp_done (ramp_done_i),
        .ramp_go   (ramp_go_o),
        .chan_on   (chan_on)
    );
endmodule

// File: rtl/rss_chk.sv
// Property checker for rail_startup_seq, attached by bind.
module rss_chk
    import rss_pkg::*;
#(
    parameter int unsigned CHANNELS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  uv_ok,
    input logic [CHANNELS-1:0]   en_sync,
    input logic [CHANNELS-1:0]   chan_on,
    input logic                  refs_up,
    input logic [STEP_COUNT-1:0] step_stb,
    input logic [CHANNELS-1:0]   ramp_go,
    input logic                  fault
);
    assert_shutdown_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(|en_sync) |=> (ramp_go == '0) && (step_stb == '0));

    assert_no_strobe_low_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_stb != '0) |-> $past(uv_ok));

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_stb));

    assert_ramp_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ramp_go & ~$past(ramp_go)) != '0) |-> $past(refs_up));

    assert_ch2_waits_ch1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_go[1]) |-> $past(!en_sync[0] || chan_on[0]));

    assert_supply_drop_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok |=> (ramp_go == '0));

    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (ramp_go == '0) && (step_stb == '0));
endmodule

bind rail_startup_seq rss_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_ok    (uv_ok_i),
    .en_sync  (en_sync),
    .chan_on  (chan_on),
    .refs_up  (refs_up),
    .step_stb (step_stb_o),
    .ramp_go  (ramp_go_o),
    .fault    (fault_o)
);

// File: tb/sim_rail_startup_seq.sv
// Sweep bench for rail_startup_seq: priority windows, timeouts, supply loss.
module sim_rail_startup_seq;
    localparam int CH = 2;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] en = '0;
    logic          uv = 1'b0;
    logic          done = 1'b0;
    logic [TW-1:0] tmo = 4'd15;
    logic [CH-1:0] rdone = '0;
    logic [4:0]    stb;
    logic [CH-1:0] go;
    logic          flt;
    int            checks = 0;
    int            fails = 0;

    always #2 clk = ~clk;

    rail_startup_seq #(.CHANNELS(CH), .TMO_W(TW), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en_i   (en),
        .uv_ok_i     (uv),
        .step_done_i (done),
        .step_tmo_i  (tmo),
        .ramp_done_i (rdone),
        .step_stb_o  (stb),
        .ramp_go_o   (go),
        .fault_o     (flt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wait_stb(output int got);
        got = 0;
        for (int i = 0; i < 40; i++) begin
            if (stb != 0) begin
                got = int'(stb);
                return;
            end
            tick();
        end
    endtask

    // Expect and acknowledge steps from..upto in order (R3).
    task automatic steps(input int from, input int upto);
        int g;
        for (int k = from; k <= upto; k++) begin
            wait_stb(g);
            chk("R3 step order", g, 1 << k);
            done = 1'b1;
            tick();
            done = 1'b0;
        end
    endtask

    task automatic shut();
        en = '0;
        rdone = '0;
        done = 1'b0;
        idle(4);
    endtask

    // Pulse channel-1 target reached; channel 2 must follow two cycles on.
    task automatic release_ch2(input string req);
        rdone[0] = 1'b1;
        tick();
        rdone[0] = 1'b0;
        chk({req, " ch2 still held"}, int'(go), 1);
        tick();
        chk({req, " ch2 starts"}, int'(go), 3);
    endtask

    initial begin
        int g;
        int seen;
        tick();
        idle(2);
        chk("R1 reset strobes", int'(stb), 0);
        chk("R1 reset ramps", int'(go), 0);
        chk("R1 reset fault", int'(flt), 0);
        rst_n = 1'b1;

        // R1: handshakes ignored in shutdown.
        uv = 1'b1;
        done = 1'b1;
        rdone = 2'b11;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            seen = seen | int'(stb) | int'(go);
        end
        done = 1'b0;
        rdone = '0;
        chk("R1 shutdown ignores handshakes", seen, 0);

        // R2: no strobe with supply low.
        uv = 1'b0;
        en = 2'b01;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            seen = seen | int'(stb);
        end
        chk("R2 no strobe while supply low", seen, 0);
        uv = 1'b1;
        shut();

        // R5 (d<0) and R6 (d>=0): channel 2 enabled at or after channel 1.
        for (int d = -1; d <= 4; d++) begin
            string r;
            r = (d < 0) ? "R5" : "R6";
            shut();
            en = (d < 0) ? 2'b11 : 2'b01;
            steps(0, 4);
            chk("R4 no ramp at refs done", int'(go), 0);
            tick();
            chk("R4 ch1 ramps one cycle later", int'(go), 1);
            if (d >= 0) begin
                idle(d);
                en = 2'b11;
            end
            idle(5);
            chk({r, " ch2 held during ch1 ramp"}, int'(go), 1);
            release_ch2(r);
        end

        // R7: channel 2 first, channel 1 joins during each shared step.
        for (int s = 0; s <= 4; s++) begin
            shut();
            en = 2'b10;
            steps(0, s - 1);
            wait_stb(g);
            chk("R7 stalled step", g, 1 << s);
            en = 2'b11;
            idle(3);
            done = 1'b1;
            tick();
            done = 1'b0;
            steps(s + 1, 4);
            tick();
            chk("R7 ch1 ramps first", int'(go), 1);
            idle(3);
            chk("R7 ch2 held", int'(go), 1);
            release_ch2("R7");
        end

        // R8: channel 2 ramping, channel 1 joins after d cycles.
        for (int d = 0; d <= 3; d++) begin
            shut();
            en = 2'b10;
            steps(0, 4);
            tick();
            chk("R4 ch2 alone ramps", int'(go), 2);
            idle(d);
            en = 2'b11;
            idle(2);
            chk("R8 ch1 not yet", int'(go), 2);
            tick();
            chk("R8 ch1 starts at once, ch2 kept", int'(go), 3);
        end

        // R11: drop channel 1 only, with both channels on.
        rdone = 2'b11;
        tick();
        rdone = '0;
        en = 2'b10;
        seen = 0;
        idle(2);
        chk("R11 sync delay keeps ch1", int'(go), 3);
        tick();
        chk("R11 only ch1 drops", int'(go), 2);
        for (int i = 0; i < 4; i++) begin
            tick();
            seen = seen | int'(stb);
        end
        chk("R11 no shared restart", seen, 0);
        chk("R11 ch2 unaffected", int'(go), 2);

        // R12: re-enable channel 1 with shared steps complete.
        en = 2'b11;
        seen = 0;
        for (int i = 0; i < 2; i++) begin
            tick();
            seen = seen | int'(stb);
        end
        chk("R12 ch1 not yet", int'(go), 2);
        tick();
        seen = seen | int'(stb);
        chk("R12 ch1 ramps directly", int'(go), 3);
        chk("R12 no step strobes", seen, 0);

        // R9: supply drop and automatic restart.
        uv = 1'b0;
        tick();
        chk("R9 both channels off at once", int'(go), 0);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            seen = seen | int'(stb);
        end
        chk("R2 no strobe during supply loss", seen, 0);
        uv = 1'b1;
        wait_stb(g);
        chk("R9 restart from trim capture", g, 1);
        done = 1'b1;
        tick();
        done = 1'b0;
        steps(1, 4);
        tick();
        chk("R9 ch1 first after restart", int'(go), 1);

        // R10: cycle limit T at every shared step.
        for (int t = 1; t <= 4; t++) begin
            for (int s = 0; s <= 4; s++) begin
                shut();
                tmo = 4'(t);
                en = 2'b01;
                steps(0, s - 1);
                wait_stb(g);
                chk("R10 stalled step", g, 1 << s);
                idle(t - 1);
                chk("R10 no fault before limit", int'(flt), 0);
                tick();
                chk("R10 fault at limit", int'(flt), 1);
                chk("R10 outputs quiet", int'(stb) | int'(go), 0);
                seen = 0;
                for (int i = 0; i < 3; i++) begin
                    tick();
                    seen = seen | int'(stb) | int'(go);
                end
                chk("R10 fault holds without restart", int'(flt) + seen, 1);
                en = '0;
                idle(2);
                chk("R10 fault held through sync", int'(flt), 1);
                tick();
                chk("R10 fault clears", int'(flt), 0);
            end
        end
        tmo = 4'd15;
        shut();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule